// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes in one asynchronous serial line and turns it into characters. All its logic runs on the system clock. A one-cycle enable, `rxc_en`, marks each rising edge of the receive sampling clock. Software-facing configuration inputs select several settings. The character length can be five to eight data bits. Parity can be off, even or odd. The sampling clock can run at 1, 16, 32 or 64 times the bit rate. Assembled characters go into a three-entry queue. Each queue entry holds a character together with its own parity, framing and overrun flags.

At the higher sampling rates, a low level on the idle line only starts a character if the line is still low half a bit time later. Shorter pulses are dropped. A character whose stop bit reads low has a framing error. After such a character, the search for the next start bit waits an extra half bit, so the bad stop bit is not taken as a new start bit. An all-zero character with a framing error counts as a line break. The block raises one pulse when the break begins and another when the line first returns high. Parity and overrun errors are also held in two sticky status outputs until an error-clear strobe is applied.

The line input `rxd` is expected to be synchronous to `clk`. The surrounding logic takes characters from the queue with `rd_en`.

Top module: `async_rx`

## Requirements
- R1: `cfg_bits` selects the data length (0 = 5, 1 = 6, 2 = 7, 3 = 8 bits). Bits arrive least significant first. They appear in the low bits of `rd_data`, and the unused upper bits read 0.
- R2: With `cfg_par_en` = 1, one parity bit follows the data. `cfg_par_odd` = 0 means even parity and 1 means odd parity. The entry's `rd_par_err` is 1 when the count of ones over the data and parity bits does not match the selected parity. With `cfg_par_en` = 0, `rd_par_err` is 0.
- R3: At rate codes 1 to 3, the first `rxc_en` tick that sees `rxd` = 0 on the idle line is rechecked M/2 ticks later. If `rxd` is 1 at that point, no character is assembled and nothing enters the queue.
- R4: `cfg_rate` codes 0, 1, 2 and 3 select M = 1, 16, 32 and 64 ticks per bit. At M = 1, the first low tick is taken as the start bit, and each following tick samples exactly one bit.
- R5: A stop bit sampled low sets `rd_frm_err` on that entry. Unless the character is a break, the start-bit search resumes M/2 ticks later than normal (at once for M = 1).
- R6: A character whose data bits are all 0 and whose stop bit is low is a break. It is queued with `rd_frm_err` = 1, and `brk_start` pulses for one cycle. `brk_end` pulses for one cycle on the first later tick that sees `rxd` = 1. Until then, no new character starts.
- R7: The queue holds 3 entries in arrival order. `rd_valid` is 1 while the queue is not empty. `rd_en` with `rd_valid` = 1 removes the head entry. `rd_en` on an empty queue has no effect.
- R8: A character that completes while the queue is full (and no read happens in the same cycle) replaces the newest entry with `rd_ovr_err` = 1. The older entries are kept, and `ovr_evt` pulses for one cycle.
- R9: `stat_par` and `stat_ovr` become 1 when an entry with a parity error or an overrun enters the queue. They stay 1 until `err_clr` is pulsed.
- R10: After reset, `rd_valid`, `brk_start`, `brk_end`, `ovr_evt`, `stat_par` and `stat_ovr` are 0, and the receiver is hunting for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxc_en | input | 1 | One-cycle pulse per rising edge of the sampling clock |
| rxd | input | 1 | Serial line, idle high |
| cfg_bits | input | 2 | Data length code (0..3 = 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_rate | input | 2 | Ticks per bit code (0..3 = 1, 16, 32, 64) |
| err_clr | input | 1 | Clears the sticky parity and overrun status |
| rd_en | input | 1 | Removes the head queue entry |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 8 | Head entry character |
| rd_par_err | output | 1 | Head entry parity error |
| rd_frm_err | output | 1 | Head entry framing error |
| rd_ovr_err | output | 1 | Head entry overrun flag |
| brk_start | output | 1 | Pulse: break detected |
| brk_end | output | 1 | Pulse: break ended |
| ovr_evt | output | 1 | Pulse: a full queue overwrote its newest entry |
| stat_par | output | 1 | Sticky parity error status |
| stat_ovr | output | 1 | Sticky overrun status |

## Verification
A tick counter that loses its place shows up within one character. The bits become shifted, or a parity or framing flag appears on a character that was sent cleanly. A receiver that fails to return to hunting shows up as a missing or extra queue entry when the next frame arrives. A queue whose count or order is wrong shows up at the very next reads as a character out of sequence, or as an overrun flag on the wrong entry. A stuck break state is exposed by the first character sent after the line returns high, which never appears.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_BRK,
        S_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par;
        logic              frm;
        logic              ovr;
    } rx_entry_t;

endpackage

// File: rtl/arx_rate_decode.sv
module arx_rate_decode
    import arx_pkg::*;
(
    input  logic [1:0]       rate_i,
    output logic [CNT_W-1:0] full_m1_o,
    output logic [CNT_W-1:0] half_m1_o,
    output logic             is_x1_o
);

    always_comb begin
        unique case (rate_i)
            2'd0: begin full_m1_o = CNT_W'(0);  half_m1_o = CNT_W'(0);  end
            2'd1: begin full_m1_o = CNT_W'(15); half_m1_o = CNT_W'(7);  end
            2'd2: begin full_m1_o = CNT_W'(31); half_m1_o = CNT_W'(15); end
            default: begin full_m1_o = CNT_W'(63); half_m1_o = CNT_W'(31); end
        endcase
        is_x1_o = (rate_i == 2'd0);
    end

endmodule

// File: rtl/arx_frame_engine.sv
module arx_frame_engine
    import arx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rxd_i,
    input  logic [1:0]       bits_i,
    input  logic             par_en_i,
    input  logic             par_odd_i,
    input  logic [CNT_W-1:0] full_m1_i,
    input  logic [CNT_W-1:0] half_m1_i,
    input  logic             is_x1_i,
    output logic             push_o,
    output rx_entry_t        entry_o,
    output logic             brk_start_o,
    output logic             brk_end_o
);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        idx;
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              brk_start;
        logic              brk_end;
    } eng_t;

    eng_t q, d;
    logic [2:0] last_idx;

    assign last_idx = 3'(bits_i) + 3'd4;

    always_comb begin
        d             = q;
        d.brk_start   = 1'b0;
        d.brk_end     = 1'b0;
        push_o        = 1'b0;
        entry_o.data  = q.data;
        entry_o.par   = par_en_i & q.perr;
        entry_o.frm   = ~rxd_i;
        entry_o.ovr   = 1'b0;
        if (tick_i) begin
            unique case (q.state)
                S_IDLE: begin
                    if (!rxd_i) begin
                        d.data = '0;
                        d.idx  = 3'd0;
                        d.perr = 1'b0;
                        if (is_x1_i) begin
                            d.state = S_DATA;
                            d.cnt   = CNT_W'(0);
                        end else begin
                            d.state = S_START;
                            d.cnt   = half_m1_i;
                        end
                    end
                end
                S_START: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end else if (rxd_i) begin
                        d.state = S_IDLE;
                    end else begin
                        d.state = S_DATA;
                        d.cnt   = full_m1_i;
                    end
                end
                S_DATA: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end else begin
                        d.data[q.idx] = rxd_i;
                        d.cnt         = full_m1_i;
                        if (q.idx == last_idx) begin
                            d.state = par_en_i ? S_PAR : S_STOP;
                        end else begin
                            d.idx = q.idx + 3'd1;
                        end
                    end
                end
                S_PAR: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end else begin
                        d.perr  = (^q.data) ^ rxd_i ^ par_odd_i;
                        d.state = S_STOP;
                        d.cnt   = full_m1_i;
                    end
                end
                S_STOP: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end else begin
                        push_o = 1'b1;
                        if (rxd_i) begin
                            d.state = S_IDLE;
                        end else if (q.data == '0) begin
                            d.state     = S_BRK;
                            d.brk_start = 1'b1;
                        end else if (is_x1_i) begin
                            d.state = S_IDLE;
                        end else begin
                            d.state = S_HOLD;
                            d.cnt   = half_m1_i;
                        end
                    end
                end
                S_BRK: begin
                    if (rxd_i) begin
                        d.state   = S_IDLE;
                        d.brk_end = 1'b1;
                    end
                end
                S_HOLD: begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end else begin
                        d.state = S_IDLE;
                    end
                end
                default: d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, cnt: '0, idx: '0, data: '0,
                   perr: 1'b0, brk_start: 1'b0, brk_end: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign brk_start_o = q.brk_start;
    assign brk_end_o   = q.brk_end;

    // R3: a line back high at the mid-start recheck sends the engine back to hunting
    p_spike_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_START && tick_i && q.cnt == '0 && rxd_i) |=> (q.state == S_IDLE));

    // R5: a non-break framing error enters the half-bit hold-off at rates above x1
    p_frm_holdoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_STOP && tick_i && q.cnt == '0 && !rxd_i && q.data != '0 && !is_x1_i)
        |=> (q.state == S_HOLD && q.cnt == $past(half_m1_i)));

    // R6: a break end pulse is only produced out of the break state
    p_break_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_end_o) |-> $past(q.state == S_BRK));

    // R6: while in break, no character is pushed
    p_break_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_BRK) |-> !push_o);

endmodule

// File: rtl/arx_entry_fifo.sv
module arx_entry_fifo
    import arx_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  rx_entry_t entry_i,
    input  logic      pop_i,
    output logic      valid_o,
    output rx_entry_t head_o,
    output logic      ovr_evt_o
);

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [CW-1:0]         cnt;
        logic                  ovr_evt;
    } fifo_t;

    fifo_t q, d;
    rx_entry_t wr_entry;

    always_comb begin
        d         = q;
        d.ovr_evt = 1'b0;
        wr_entry  = entry_i;
        if (pop_i && q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                d.mem[i] = q.mem[i+1];
            end
            d.cnt = q.cnt - CW'(1);
        end
        if (push_i) begin
            if (d.cnt < CW'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CW'(i) == d.cnt) d.mem[i] = wr_entry;
                end
                d.cnt = d.cnt + CW'(1);
            end else begin
                wr_entry.ovr     = 1'b1;
                d.mem[DEPTH-1]   = wr_entry;
                d.ovr_evt        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign valid_o   = (q.cnt != '0);
    assign head_o    = q.mem[0];
    assign ovr_evt_o = q.ovr_evt;

    // R7: occupancy never exceeds the queue depth
    p_fifo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));

    // R7: a pop on an empty queue leaves it empty
    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == '0 && pop_i && !push_i) |=> (q.cnt == '0));

    // R8: a push into a full queue without a pop keeps it full and marks the newest entry
    p_overrun_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && q.cnt == CW'(DEPTH))
        |=> (q.cnt == CW'(DEPTH) && q.mem[DEPTH-1].ovr && ovr_evt_o));

endmodule

// File: rtl/async_rx.sv
module async_rx
    import arx_pkg::*;
#(
    parameter int FIFO_DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxc_en,
    input  logic              rxd,
    input  logic [1:0]        cfg_bits,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_rate,
    input  logic              err_clr,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_par_err,
    output logic              rd_frm_err,
    output logic              rd_ovr_err,
    output logic              brk_start,
    output logic              brk_end,
    output logic              ovr_evt,
    output logic              stat_par,
    output logic              stat_ovr
);

    logic [CNT_W-1:0] full_m1, half_m1;
    logic             is_x1;
    logic             push;
    rx_entry_t        entry, head;

    typedef struct packed {
        logic par;
        logic ovr;
    } sticky_t;

    sticky_t st_q, st_d;

    arx_rate_decode u_rate (
        .rate_i    (cfg_rate),
        .full_m1_o (full_m1),
        .half_m1_o (half_m1),
        .is_x1_o   (is_x1)
    );

    arx_frame_engine u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (rxc_en),
        .rxd_i       (rxd),
        .bits_i      (cfg_bits),
        .par_en_i    (cfg_par_en),
        .par_odd_i   (cfg_par_odd),
        .full_m1_i   (full_m1),
        .half_m1_i   (half_m1),
        .is_x1_i     (is_x1),
        .push_o      (push),
        .entry_o     (entry),
        .brk_start_o (brk_start),
        .brk_end_o   (brk_end)
    );

    arx_entry_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .entry_i   (entry),
        .pop_i     (rd_en),
        .valid_o   (rd_valid),
        .head_o    (head),
        .ovr_evt_o (ovr_evt)
    );

    always_comb begin
        st_d = st_q;
        if (err_clr) begin
            st_d.par = 1'b0;
            st_d.ovr = 1'b0;
        end
        if (push && entry.par) st_d.par = 1'b1;
        if (ovr_evt)           st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = head.data;
    assign rd_par_err = head.par;
    assign rd_frm_err = head.frm;
    assign rd_ovr_err = head.ovr;
    assign stat_par   = st_q.par;
    assign stat_ovr   = st_q.ovr;

    // R9: sticky parity status holds until cleared
    p_sticky_par_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_par && !err_clr) |=> stat_par);

    // R9: sticky overrun status holds until cleared
    p_sticky_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ovr && !err_clr) |=> stat_ovr);

    // R8: every overrun event leaves the overrun status set
    p_ovr_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> stat_ovr);

endmodule

// File: tb/async_rx_test.sv
module async_rx_test;
    import arx_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxc_en = 1'b0;
    logic rxd = 1'b1;
    logic [1:0] cfg_bits = 2'd3;
    logic cfg_par_en = 1'b0;
    logic cfg_par_odd = 1'b0;
    logic [1:0] cfg_rate = 2'd1;
    logic err_clr = 1'b0;
    logic rd_en;
    logic mon_rd = 1'b0;
    logic man_rd = 1'b0;
    logic mon_on = 1'b1;
    logic rd_valid, rd_par_err, rd_frm_err, rd_ovr_err;
    logic [7:0] rd_data;
    logic brk_start, brk_end, ovr_evt, stat_par, stat_ovr;

    int n_checks = 0;
    int n_fail = 0;
    int n_bs = 0;
    int n_be = 0;
    int n_ov = 0;
    int div = 0;
    bit done = 0;
    logic [10:0] exp_q[$];

    assign rd_en = mon_rd | man_rd;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        div <= (div == 2) ? 0 : div + 1;
        rxc_en <= (div == 2);
    end

    async_rx uut (
        .clk(clk), .rst_n(rst_n), .rxc_en(rxc_en), .rxd(rxd),
        .cfg_bits(cfg_bits), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_rate(cfg_rate), .err_clr(err_clr), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_par_err(rd_par_err),
        .rd_frm_err(rd_frm_err), .rd_ovr_err(rd_ovr_err),
        .brk_start(brk_start), .brk_end(brk_end), .ovr_evt(ovr_evt),
        .stat_par(stat_par), .stat_ovr(stat_ovr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: pops each produced entry and compares it
    always @(negedge clk) begin
        if (brk_start) n_bs++;
        if (brk_end)   n_be++;
        if (ovr_evt)   n_ov++;
        if (mon_rd) begin
            mon_rd = 1'b0;
        end else if (mon_on && rd_valid) begin
            logic [10:0] got;
            got = {rd_data, rd_par_err, rd_frm_err, rd_ovr_err};
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected entry", int'(got), 0);
            end else begin
                logic [10:0] want;
                want = exp_q.pop_front();
                check(got == want, "R1/R2/R5/R7", "entry {data,par,frm,ovr}",
                      int'(got), int'(want));
            end
            mon_rd = 1'b1;
        end
    end

    task automatic wait_tick();
        do @(negedge clk); while (!rxc_en);
    endtask

    task automatic hold_line(input logic v, input int ticks);
        rxd = v;
        repeat (ticks) wait_tick();
    endtask

    // drives one frame; a high stop bit is followed by two bit times of idle
    task automatic send_char(input logic [7:0] dat, input int nb, input int m,
                             input bit bad_par, input bit stop_hi);
        logic [7:0] mask;
        logic pb;
        mask = 8'(( 1 << nb) - 1);
        pb = (^(dat & mask)) ^ cfg_par_odd ^ bad_par;
        hold_line(1'b0, m);
        for (int i = 0; i < nb; i++) hold_line(dat[i], m);
        if (cfg_par_en) hold_line(pb, m);
        if (stop_hi) hold_line(1'b1, 3 * m);
        else hold_line(1'b0, m);
    endtask

    task automatic expect_item(input logic [7:0] dat, input bit p, input bit f, input bit o);
        exp_q.push_back({dat, p, f, o});
    endtask

    task automatic drain(input string req);
        int t = 0;
        while ((exp_q.size() != 0 || rd_valid) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, req, "expected entries left", exp_q.size(), 0);
    endtask

    task automatic man_read(input logic [7:0] dat, input bit o, input string req);
        @(negedge clk);
        check(rd_valid == 1'b1, req, "rd_valid before read", rd_valid, 1);
        check(rd_data == dat, req, "read data", rd_data, dat);
        check(rd_ovr_err == o, req, "read overrun flag", rd_ovr_err, o);
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #3000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        check(rd_valid == 1'b0, "R10", "rd_valid in reset", rd_valid, 0);
        check(stat_par == 1'b0 && stat_ovr == 1'b0, "R10", "sticky status in reset",
              {stat_par, stat_ovr}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(brk_start == 1'b0 && brk_end == 1'b0 && ovr_evt == 1'b0, "R10",
              "event pulses after reset", {brk_start, brk_end, ovr_evt}, 0);
        wait_tick();
        hold_line(1'b1, 20);

        // R1 R4: x16, 8 bits, no parity
        cfg_rate = 2'd1; cfg_bits = 2'd3; cfg_par_en = 1'b0;
        expect_item(8'hA5, 0, 0, 0); send_char(8'hA5, 8, 16, 0, 1);
        expect_item(8'h3C, 0, 0, 0); send_char(8'h3C, 8, 16, 0, 1);
        drain("R1");

        // R4 R2: x1, 5 bits, even parity, good then bad parity
        cfg_rate = 2'd0; cfg_bits = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        expect_item(8'h15, 0, 0, 0); send_char(8'hF5, 5, 1, 0, 1);
        drain("R4");
        check(stat_par == 1'b0, "R9", "stat_par after good parity", stat_par, 0);
        expect_item(8'h0A, 1, 0, 0); send_char(8'h0A, 5, 1, 1, 1);
        drain("R2");
        expect_item(8'h13, 0, 0, 0); send_char(8'h13, 5, 1, 0, 1);
        drain("R2");
        check(stat_par == 1'b1, "R9", "stat_par sticky", stat_par, 1);
        pulse_clr();
        check(stat_par == 1'b0, "R9", "stat_par after err_clr", stat_par, 0);

        // R2: x32, 7 bits, odd parity
        cfg_rate = 2'd2; cfg_bits = 2'd2; cfg_par_odd = 1'b1;
        expect_item(8'h5A, 0, 0, 0); send_char(8'hDA, 7, 32, 0, 1);
        expect_item(8'h01, 1, 0, 0); send_char(8'h01, 7, 32, 1, 1);
        drain("R2");
        pulse_clr();

        // R1 R4: x64, 6 bits, no parity
        cfg_rate = 2'd3; cfg_bits = 2'd1; cfg_par_en = 1'b0;
        expect_item(8'h2D, 0, 0, 0); send_char(8'h2D, 6, 64, 0, 1);
        drain("R1");

        // R3: spike of 3 ticks at x16 is dropped
        cfg_rate = 2'd1; cfg_bits = 2'd3;
        hold_line(1'b0, 3);
        hold_line(1'b1, 40);
        check(rd_valid == 1'b0 && exp_q.size() == 0, "R3", "spike produced entry",
              rd_valid, 0);
        expect_item(8'h6E, 0, 0, 0); send_char(8'h6E, 8, 16, 0, 1);
        drain("R3");

        // R5: framing error, line stays low 4 ticks past the stop bit
        expect_item(8'h55, 0, 1, 0); send_char(8'h55, 8, 16, 0, 0);
        hold_line(1'b0, 4);
        hold_line(1'b1, 40);
        expect_item(8'h81, 0, 0, 0); send_char(8'h81, 8, 16, 0, 1);
        drain("R5");

        // R6: break start and end
        n_bs = 0; n_be = 0;
        expect_item(8'h00, 0, 1, 0); send_char(8'h00, 8, 16, 0, 0);
        hold_line(1'b0, 30);
        check(n_bs == 1, "R6", "brk_start pulses during break", n_bs, 1);
        check(n_be == 0, "R6", "brk_end while line low", n_be, 0);
        hold_line(1'b1, 20);
        check(n_be == 1, "R6", "brk_end pulses after high", n_be, 1);
        expect_item(8'hC3, 0, 0, 0); send_char(8'hC3, 8, 16, 0, 1);
        drain("R6");

        // R7 R8: overrun with reads held off
        mon_on = 1'b0; n_ov = 0;
        cfg_rate = 2'd0;
        send_char(8'h11, 8, 1, 0, 1);
        send_char(8'h22, 8, 1, 0, 1);
        send_char(8'h33, 8, 1, 0, 1);
        check(n_ov == 0 && stat_ovr == 1'b0, "R8", "overrun before full", n_ov, 0);
        send_char(8'h44, 8, 1, 0, 1);
        check(n_ov == 1, "R8", "ovr_evt pulse count", n_ov, 1);
        check(stat_ovr == 1'b1, "R9", "stat_ovr set", stat_ovr, 1);
        man_read(8'h11, 0, "R7");
        man_read(8'h22, 0, "R7");
        man_read(8'h44, 1, "R8");
        @(negedge clk);
        check(rd_valid == 1'b0, "R7", "queue empty after reads", rd_valid, 0);
        man_rd = 1'b1; @(negedge clk); man_rd = 1'b0; @(negedge clk);
        check(rd_valid == 1'b0, "R7", "read on empty queue", rd_valid, 0);
        check(stat_ovr == 1'b1, "R9", "stat_ovr held", stat_ovr, 1);
        pulse_clr();
        check(stat_ovr == 1'b0, "R9", "stat_ovr after err_clr", stat_ovr, 0);
        mon_on = 1'b1;

        finish_up();
    end

endmodule